// File: doc/BRIEF.md
# Streaming Hamming ECC Generator

This block sits beside a byte-wide data path and builds a Hamming-style error-correcting code from the bytes as they go past. It stores no data. For each accepted byte it updates a set of parity accumulators. When a block of the configured length is complete, it packs the accumulators into a 24-bit code and latches that code into a result register. The code can correct any single-bit error in the block and detect any double-bit error.

A layout bit selects the block size. In the short layout, the first 256 bytes give one code and the next 256 bytes give a second code. In the long layout, one code covers 512 bytes and the second result register is not used. The layout bit is sampled on the clear strobe. The clear strobe also resets both results to all ones, drops the done flag and restarts the byte count.

Once the last code of the layout is latched, the done flag rises. From then on the block ignores all traffic until the next clear. The codes are stored bit-inverted, so a block of erased (all 0xFF) bytes gives an all-ones code.

Top module: `ecc_stream_gen`

## Requirements
- R1: After reset, both code outputs are 24'hFFFFFF, done_o is 0, and the short layout is selected.
- R2: clear_i sampled high at a rising edge has these effects at that edge: both codes become 24'hFFFFFF, done_o becomes 0, the byte count returns to zero and the layout is taken from mode_i. A byte offered in the same cycle as clear_i is dropped.
- R3: With mode_i=0 at clear, code1_o is updated on the edge that accepts byte 255. It then holds the code of bytes 0 to 255, with address a = byte index mod 256.
- R4: With mode_i=0, code2_o is updated on the edge that accepts byte 511 and holds the code of bytes 256 to 511. done_o rises on that same edge.
- R5: With mode_i=1 at clear, code1_o is updated on the edge that accepts byte 511 and holds the code of bytes 0 to 511. done_o rises on that edge, code2_o stays 24'hFFFFFF, and code1_o keeps its cleared value before that edge.
- R6: Short-layout packing. Bit 2k is the inverse of the XOR of the byte parities of all bytes whose address bit k is 0, and bit 2k+1 is the same for address bit k = 1 (k = 0..7). Let C be the XOR of all bytes in the block. Bits 16+2j and 17+2j are the inverse of the XOR of the bits C[b] whose bit-index b has bit j equal to 0 and 1 respectively (j = 0..2). Bits 23:22 are 1.
- R7: Long-layout packing. Line pairs k = 0..8 sit in bits 2k and 2k+1, and the column pairs j = 0..2 sit in bits 18+2j and 19+2j, with the same definitions as R6.
- R8: A block of all-0xFF bytes yields 24'hFFFFFF in either layout.
- R9: While done_o is 1 and clear_i is 0, accepted-looking traffic changes neither code nor done_o.
- R10: Flipping one data bit in a block changes exactly one bit of every parity pair of that block's code and leaves the pad bits unchanged.
- R11: Cycles with valid_i low do not advance the count or alter any accumulator, whatever data_i carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte on the data path |
| valid_i | input | 1 | data_i carries a byte this cycle |
| mode_i | input | 1 | Layout select sampled on clear: 0 = two 256-byte codes, 1 = one 512-byte code |
| clear_i | input | 1 | Clear strobe, re-arms a calculation |
| code1_o | output | 24 | First result register |
| code2_o | output | 24 | Second result register |
| done_o | output | 1 | Final code of the layout latched |

## Verification
The assertions check, on every cycle, the clear effects, the freeze after done, the idle second register and the pad bits in the short layout. They also check that the codes and the done flag move only on the edge of an accepted byte. Only the bench scenarios can show that a latched code equals the parity definition. The same holds for the latch happening at exactly byte 255 or 511, a byte dropped under clear, and a single flipped bit touching one bit of every pair. The bench compares these against a bench-side model over random and directed data.

// File: rtl/ecc_stream_pkg.sv
package ecc_stream_pkg;
    localparam int BYTE_W    = 8;
    localparam int SMALL_AW  = 8;
    localparam int LARGE_AW  = SMALL_AW + 1;
    localparam int COL_SEL_W = $clog2(BYTE_W);
    localparam int CODE_W    = 2 * LARGE_AW + 2 * COL_SEL_W;
endpackage

// File: rtl/ecc_line_acc.sv
module ecc_line_acc #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [AW-1:0] addr_i,
    input  logic          par_i,
    output logic [AW-1:0] even_o,
    output logic [AW-1:0] odd_o
);
    typedef struct packed {
        logic [AW-1:0] ev;
        logic [AW-1:0] od;
    } line_t;

    line_t         acc_d, acc_q, acc_upd;
    logic [AW-1:0] ev_hit, od_hit;

    for (genvar k = 0; k < AW; k++) begin : g_bit
        assign ev_hit[k] = en_i & ~addr_i[k] & par_i;
        assign od_hit[k] = en_i &  addr_i[k] & par_i;
    end

    always_comb begin
        acc_upd.ev = acc_q.ev ^ ev_hit;
        acc_upd.od = acc_q.od ^ od_hit;
        acc_d      = clr_i ? '0 : acc_upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign even_o = acc_upd.ev;
    assign odd_o  = acc_upd.od;
endmodule

// File: rtl/ecc_col_acc.sv
module ecc_col_acc #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [BW-1:0] data_i,
    output logic          par_o,
    output logic [BW-1:0] col_o
);
    logic [BW-1:0] col_d, col_q, col_upd;

    always_comb begin
        col_upd = en_i ? (col_q ^ data_i) : col_q;
        col_d   = clr_i ? '0 : col_upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign par_o = ^data_i;
    assign col_o = col_upd;
endmodule

// File: rtl/ecc_pack.sv
module ecc_pack #(
    parameter int BW  = 8,
    parameter int SAW = 8,
    localparam int LAW    = SAW + 1,
    localparam int CSW    = $clog2(BW),
    localparam int CODE_W = 2 * LAW + 2 * CSW,
    localparam int PAD_W  = CODE_W - 2 * SAW - 2 * CSW
) (
    input  logic              mode_i,
    input  logic [LAW-1:0]    even_i,
    input  logic [LAW-1:0]    odd_i,
    input  logic [BW-1:0]     col_i,
    output logic [CODE_W-1:0] code_o
);
    function automatic logic [BW-1:0] col_mask(input int j, input int sel);
        logic [BW-1:0] m;
        for (int b = 0; b < BW; b++) m[b] = (((b >> j) % 2) == sel);
        return m;
    endfunction

    logic [2*LAW-1:0]  lines;
    logic [2*CSW-1:0]  cols;
    logic [CODE_W-1:0] raw_small, raw_large;

    for (genvar k = 0; k < LAW; k++) begin : g_line
        assign lines[2*k]   = even_i[k];
        assign lines[2*k+1] = odd_i[k];
    end

    for (genvar j = 0; j < CSW; j++) begin : g_col
        assign cols[2*j]   = ^(col_i & col_mask(j, 0));
        assign cols[2*j+1] = ^(col_i & col_mask(j, 1));
    end

    assign raw_small = {{PAD_W{1'b0}}, cols, lines[2*SAW-1:0]};
    assign raw_large = {cols, lines};
    assign code_o    = ~(mode_i ? raw_large : raw_small);
endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
    import ecc_stream_pkg::*;
#(
    parameter int BW  = BYTE_W,
    parameter int SAW = SMALL_AW,
    localparam int LAW    = SAW + 1,
    localparam int CSW    = $clog2(BW),
    localparam int CODE_W = 2 * LAW + 2 * CSW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BW-1:0]     data_i,
    input  logic              valid_i,
    input  logic              mode_i,
    input  logic              clear_i,
    output logic [CODE_W-1:0] code1_o,
    output logic [CODE_W-1:0] code2_o,
    output logic              done_o
);
    typedef struct packed {
        logic [LAW-1:0]    cnt;
        logic              mode;
        logic [CODE_W-1:0] code1;
        logic [CODE_W-1:0] code2;
        logic              done;
    } ctl_t;

    ctl_t              state_d, state_q;
    logic              accept, blk_last, blk_end, acc_clr, byte_par;
    logic [LAW-1:0]    line_addr, ev, od;
    logic [BW-1:0]     col;
    logic [CODE_W-1:0] packed_code;

    assign accept    = valid_i && !state_q.done && !clear_i;
    assign blk_last  = state_q.mode ? (state_q.cnt == '1)
                                    : (state_q.cnt[SAW-1:0] == '1);
    assign blk_end   = accept && blk_last;
    assign acc_clr   = clear_i || blk_end;
    assign line_addr = state_q.mode ? state_q.cnt
                                    : {{(LAW-SAW){1'b0}}, state_q.cnt[SAW-1:0]};

    ecc_col_acc #(.BW(BW)) u_col (
        .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .en_i(accept),
        .data_i(data_i), .par_o(byte_par), .col_o(col)
    );

    ecc_line_acc #(.AW(LAW)) u_line (
        .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .en_i(accept),
        .addr_i(line_addr), .par_i(byte_par), .even_o(ev), .odd_o(od)
    );

    ecc_pack #(.BW(BW), .SAW(SAW)) u_pack (
        .mode_i(state_q.mode), .even_i(ev), .odd_i(od), .col_i(col),
        .code_o(packed_code)
    );

    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d.cnt   = '0;
            state_d.mode  = mode_i;
            state_d.code1 = '1;
            state_d.code2 = '1;
            state_d.done  = 1'b0;
        end else if (accept) begin
            state_d.cnt = state_q.cnt + 1'b1;
            if (blk_end) begin
                if (state_q.mode) begin
                    state_d.code1 = packed_code;
                    state_d.done  = 1'b1;
                end else if (!state_q.cnt[SAW]) begin
                    state_d.code1 = packed_code;
                end else begin
                    state_d.code2 = packed_code;
                    state_d.done  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cnt   <= '0;
            state_q.mode  <= 1'b0;
            state_q.code1 <= '1;
            state_q.code2 <= '1;
            state_q.done  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign code1_o = state_q.code1;
    assign code2_o = state_q.code2;
    assign done_o  = state_q.done;
endmodule

// File: rtl/ecc_stream_gen_chk.sv
module ecc_stream_gen_chk #(
    parameter int CODE_W = 24,
    parameter int PAD_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              clear_i,
    input logic              mode_q,
    input logic [CODE_W-1:0] code1_o,
    input logic [CODE_W-1:0] code2_o,
    input logic              done_o
);
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (code1_o == '1 && code2_o == '1 && !done_o));

    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> ($stable(code1_o) && $stable(code2_o) && done_o));

    p_unused_code2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (code2_o == '1));

    p_pad_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (code1_o[CODE_W-1 -: PAD_W] == '1 && code2_o[CODE_W-1 -: PAD_W] == '1));

    p_update_needs_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(code1_o) && !$past(clear_i)) |-> $past(valid_i));

    p_done_needs_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(valid_i) && !$past(clear_i)));
endmodule

bind ecc_stream_gen ecc_stream_gen_chk #(.CODE_W(CODE_W), .PAD_W(CODE_W - 2*SAW - 2*CSW)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .clear_i(clear_i),
    .mode_q(state_q.mode), .code1_o(code1_o), .code2_o(code2_o), .done_o(done_o)
);

// File: tb/ecc_stream_gen_tb.sv
module ecc_stream_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  data_i = '0;
    logic        valid_i = 1'b0, mode_i = 1'b0, clear_i = 1'b0;
    logic [23:0] code1_o, code2_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [512];

    ecc_stream_gen u_dut (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .valid_i(valid_i),
        .mode_i(mode_i), .clear_i(clear_i), .code1_o(code1_o),
        .code2_o(code2_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model(input bit m, input int base, input int n);
        logic [17:0] lp;
        logic [7:0]  col;
        logic [5:0]  cp;
        logic [23:0] raw;
        logic        p;
        int          nk;
        lp = '0; col = '0; cp = '0;
        nk = m ? 9 : 8;
        for (int i = 0; i < n; i++) begin
            p = ^mem[base+i];
            col ^= mem[base+i];
            for (int k = 0; k < nk; k++) begin
                if (((i >> k) % 2) == 1) lp[2*k+1] ^= p;
                else                     lp[2*k]   ^= p;
            end
        end
        for (int j = 0; j < 3; j++)
            for (int b = 0; b < 8; b++) begin
                if (((b >> j) % 2) == 1) cp[2*j+1] ^= col[b];
                else                     cp[2*j]   ^= col[b];
            end
        if (m) raw = {cp, lp};
        else   raw = {2'b00, cp, lp[15:0]};
        return ~raw;
    endfunction

    function automatic logic [23:0] pair_ok(input logic [23:0] x, input bit m);
        logic ok;
        int   np;
        ok = 1'b1;
        np = m ? 12 : 11;
        for (int q = 0; q < np; q++)
            if ((x[2*q] ^ x[2*q+1]) == 1'b0) ok = 1'b0;
        if (!m && x[23:22] != 2'b00) ok = 1'b0;
        return {23'b0, ok};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        int gaps;
        gaps = $urandom_range(0, 2);
        repeat (gaps) begin
            @(negedge clk);
            valid_i = 1'b0;
            data_i  = 8'($urandom);
        end
        @(negedge clk);
        valid_i = 1'b1;
        data_i  = b;
    endtask

    task automatic send_range(input int base, input int n);
        for (int i = 0; i < n; i++) send_byte(mem[base+i]);
        @(negedge clk);
        valid_i = 1'b0;
        data_i  = 8'($urandom);
    endtask

    task automatic do_clear(input bit m, input bit with_byte);
        @(negedge clk);
        clear_i = 1'b1;
        mode_i  = m;
        valid_i = with_byte;
        data_i  = 8'($urandom);
        @(negedge clk);
        clear_i = 1'b0;
        valid_i = 1'b0;
    endtask

    task automatic fill_random();
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [23:0] ca, cb;
        int          idx;
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        chk("R1 code1 reset", code1_o, 24'hFFFFFF);
        chk("R1 code2 reset", code2_o, 24'hFFFFFF);
        chk("R1 done reset", {23'b0, done_o}, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // short layout, random data, bench-default layout from reset
        fill_random();
        send_range(0, 256);
        chk("R3 R6 code1 after block 0", code1_o, model(0, 0, 256));
        chk("R3 code2 untouched", code2_o, 24'hFFFFFF);
        chk("R3 done low after block 0", {23'b0, done_o}, 24'h0);
        send_range(256, 256);
        chk("R4 R6 code2 after block 1", code2_o, model(0, 256, 256));
        chk("R4 done after block 1", {23'b0, done_o}, 24'h1);
        ca = code1_o; cb = code2_o;
        for (int i = 0; i < 40; i++) send_byte(8'($urandom));
        @(negedge clk); valid_i = 1'b0;
        chk("R9 code1 frozen", code1_o, ca);
        chk("R9 code2 frozen", code2_o, cb);
        chk("R9 done held", {23'b0, done_o}, 24'h1);

        // long layout
        do_clear(1, 0);
        chk("R2 code1 cleared", code1_o, 24'hFFFFFF);
        chk("R2 code2 cleared", code2_o, 24'hFFFFFF);
        chk("R2 done cleared", {23'b0, done_o}, 24'h0);
        fill_random();
        send_range(0, 256);
        chk("R5 code1 idle mid long block", code1_o, 24'hFFFFFF);
        send_range(256, 256);
        chk("R5 R7 code1 long", code1_o, model(1, 0, 512));
        chk("R5 code2 unused", code2_o, 24'hFFFFFF);
        chk("R5 done long", {23'b0, done_o}, 24'h1);

        // erased data both layouts
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        do_clear(0, 0);
        send_range(0, 512);
        chk("R8 erased code1 short", code1_o, 24'hFFFFFF);
        chk("R8 erased code2 short", code2_o, 24'hFFFFFF);
        do_clear(1, 0);
        send_range(0, 512);
        chk("R8 erased code1 long", code1_o, 24'hFFFFFF);

        // clear with a byte in the same cycle, and mid-stream restart
        fill_random();
        do_clear(0, 1);
        send_range(0, 256);
        chk("R2 byte under clear dropped", code1_o, model(0, 0, 256));
        send_range(256, 100);
        do_clear(0, 0);
        send_range(0, 256);
        chk("R2 count restarts", code1_o, model(0, 0, 256));

        // R11: long idle stretches with busy data
        do_clear(0, 0);
        for (int i = 0; i < 256; i++) begin
            send_byte(mem[i]);
            repeat (3) begin
                @(negedge clk);
                valid_i = 1'b0;
                data_i  = 8'($urandom);
            end
        end
        @(negedge clk);
        chk("R11 invalid cycles ignored", code1_o, model(0, 0, 256));

        // R10 single-bit flip, short layout
        for (int t = 0; t < 3; t++) begin
            fill_random();
            do_clear(0, 0);
            send_range(0, 256);
            ca = code1_o;
            idx = $urandom_range(0, 255);
            mem[idx][$urandom_range(0, 7)] ^= 1'b1;
            do_clear(0, 0);
            send_range(0, 256);
            cb = code1_o;
            chk("R10 flip short model", cb, model(0, 0, 256));
            chk("R10 flip short pairs", pair_ok(ca ^ cb, 0), 24'h1);
        end

        // R10 single-bit flip, long layout
        fill_random();
        do_clear(1, 0);
        send_range(0, 512);
        ca = code1_o;
        mem[511][7] ^= 1'b1;
        do_clear(1, 0);
        send_range(0, 512);
        cb = code1_o;
        chk("R10 R7 flip long model", cb, model(1, 0, 512));
        chk("R10 flip long pairs", pair_ok(ca ^ cb, 1), 24'h1);

        report();
    end
endmodule